// File: doc/BRIEF.md
# SPI NOR Range Erase Sequencer

This block erases a contiguous byte range of a serial NOR flash without processor help. A host presents a start address, a byte length and a unit-select flag, then strobes `go`. The block first validates the request. Rejected requests end in a one-cycle error pulse and never touch the SPI bus. Accepted requests are walked one erase unit at a time. The unit is either a 4 KiB block or a full sector, chosen per request.

Each unit runs the same three-frame sequence, and every frame sits inside its own chip-select window. First comes a status poll, repeated until the flash reports idle. Then a write-enable frame. Then the erase frame, which carries the unit's 24-bit address. A poll that never sees the flash go idle is abandoned after a fixed number of attempts, and the whole request stops with an error. The serial shifter is built in and runs SPI mode 0 with a single chip select. Device size, sector size, poll limit and serial clock rate are parameters.

Top module: `nor_erase_seq`

## Requirements
- R1: While and after reset, with no request, `busy`, `done` and `err` are low, `spi_cs_n` is high and `spi_sclk` is low.
- R2: If start plus length is larger than the device size, `err` pulses and no chip-select window is opened. This covers a zero length whose start lies past the device end.
- R3: If start or length is not a multiple of the selected unit, `err` pulses and no chip-select window is opened. The unit is 4096 bytes when `big_unit`=0 and one sector when `big_unit`=1.
- R4: A valid request of length zero ends with a `done` pulse and no chip-select window.
- R5: Each unit begins with status-poll frames. A poll frame is two bytes: opcode 0x05, then one byte read back, where bit 0 set means the flash is still busy. Polling repeats until bit 0 reads clear.
- R6: Every erase frame is directly preceded by a one-byte frame holding opcode 0x06.
- R7: The erase frame is four bytes: opcode 0x20 (`big_unit`=0) or 0xD8 (`big_unit`=1), then the unit address, high byte first. Bits go out most significant first. Units are erased at start, start+unit, and so on, until the length is used up.
- R8: If bit 0 is still set after POLL_LIMIT polls for one unit, `err` pulses. No further frame is issued. This applies to the first unit and to any later unit.
- R9: `busy` is high from the cycle after an accepted `go` until the cycle of the single `done` or `err` pulse, in which it is low. `done` and `err` never coincide, and each lasts one cycle.
- R10: A `go` while `busy` is high is ignored. The running request is unchanged, and nothing starts after it ends.
- R11: `spi_sclk` idles low and toggles only while `spi_cs_n` is low. Between frames, `spi_cs_n` stays high for at least two serial clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, sampled only when idle |
| start_addr | input | 24 | First byte address of the range |
| byte_len | input | 25 | Range length in bytes |
| big_unit | input | 1 | 0 selects 4 KiB units, 1 selects whole sectors |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: range erased |
| err | output | 1 | One-cycle pulse: request rejected or poll timed out |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions take for granted that `spi_miso` carries a defined level whenever the shifter samples it. They also rely on `start_addr`, `byte_len` and `big_unit` being meaningful only in the cycle `go` is seen while idle. The stimulus satisfies both. A flash model in the bench always drives `spi_miso` to 0 or 1 and answers status reads from a programmable busy countdown. Request fields are changed only at the `go` strobe, or deliberately while busy to show that they are ignored. The model also counts frames, polls, erases and protocol slips, so ordering and framing faults surface as count mismatches.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam int ADDR_W = 24;
    localparam int LEN_W  = ADDR_W + 1;

    localparam logic [7:0] OP_STAT     = 8'h05;
    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_ER_SMALL = 8'h20;
    localparam logic [7:0] OP_ER_BIG   = 8'hD8;

    typedef enum logic [1:0] {
        FR_POLL  = 2'd0,
        FR_WREN  = 2'd1,
        FR_ERASE = 2'd2
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FRAME = 2'd2,
        ST_GAP   = 2'd3
    } state_e;

    // Index of the final byte in each frame kind
    function automatic logic [1:0] frame_last(frame_e k);
        case (k)
            FR_POLL: return 2'd1;
            FR_WREN: return 2'd0;
            default: return 2'd3;
        endcase
    endfunction

    // Byte to transmit at position i of a frame
    function automatic logic [7:0] frame_byte(frame_e k, logic [1:0] i,
                                              logic [ADDR_W-1:0] a, logic big);
        logic [7:0] b;
        b = 8'h00;
        case (k)
            FR_POLL: b = (i == 2'd0) ? OP_STAT : 8'h00;
            FR_WREN: b = OP_WREN;
            default: begin
                case (i)
                    2'd0:    b = big ? OP_ER_BIG : OP_ER_SMALL;
                    2'd1:    b = a[23:16];
                    2'd2:    b = a[15:8];
                    default: b = a[7:0];
                endcase
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nor_byte_shifter.sv
module nor_byte_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    output logic [7:0] rx,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic [7:0]    sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            bit_q  <= '0;
            div_q  <= '0;
            sh_q   <= '0;
            rx     <= '0;
            done   <= 1'b0;
            sclk   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh_q   <= tx;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sclk   <= 1'b0;
                end
            end else if (div_q == DW'(HALF - 1)) begin
                div_q <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign mosi = sh_q[7];

    // R11
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk);

endmodule

// File: rtl/nor_range_check.sv
module nor_range_check
    import nor_erase_pkg::*;
#(
    parameter int DEV_LOG2   = 20,
    parameter int SECT_LOG2  = 16,
    parameter int SMALL_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [LEN_W-1:0]  len,
    input  logic              big,
    output logic              ok,
    output logic              empty
);
    localparam logic [LEN_W:0]   DEV_BYTES  = (LEN_W+1)'(1) << DEV_LOG2;
    localparam logic [LEN_W-1:0] SECT_MASK  = (LEN_W'(1) << SECT_LOG2) - 1'b1;
    localparam logic [LEN_W-1:0] SMALL_MASK = (LEN_W'(1) << SMALL_LOG2) - 1'b1;

    logic [LEN_W:0]   end_sum;
    logic [LEN_W-1:0] mask;
    logic             misaligned;

    always_comb begin
        end_sum    = {2'b00, start} + {1'b0, len};
        mask       = big ? SECT_MASK : SMALL_MASK;
        misaligned = ((({1'b0, start}) | len) & mask) != '0;
        ok         = !misaligned && (end_sum <= DEV_BYTES);
        empty      = (len == '0);
    end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int DEV_LOG2   = 20,
    parameter int SECT_LOG2  = 16,
    parameter int SMALL_LOG2 = 12,
    parameter int POLL_LIMIT = 100000,
    parameter int SCLK_HALF  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic              big_unit,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PW      = $clog2(POLL_LIMIT + 1);
    localparam int GAP_CYC = 4 * SCLK_HALF;
    localparam int GW      = $clog2(GAP_CYC + 1);

    state_e            state;
    frame_e            kind;
    logic [1:0]        idx;
    logic              inflight;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  left;
    logic              big_q;
    logic [PW-1:0]     poll_cnt;
    logic [GW-1:0]     gap_cnt;
    logic              wip_q;
    logic              sh_start;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              cs_n_q;
    logic              rng_ok;
    logic              rng_empty;
    logic [LEN_W-1:0]  unit_len;
    logic              unused_rx;

    assign unit_len  = big_q ? (LEN_W'(1) << SECT_LOG2) : (LEN_W'(1) << SMALL_LOG2);
    assign spi_cs_n  = cs_n_q;
    assign unused_rx = ^sh_rx[7:1];

    nor_range_check #(
        .DEV_LOG2  (DEV_LOG2),
        .SECT_LOG2 (SECT_LOG2),
        .SMALL_LOG2(SMALL_LOG2)
    ) u_rng (
        .start(cur_addr),
        .len  (left),
        .big  (big_q),
        .ok   (rng_ok),
        .empty(rng_empty)
    );

    nor_byte_shifter #(.HALF(SCLK_HALF)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .start(sh_start),
        .tx   (frame_byte(kind, idx, cur_addr, big_q)),
        .rx   (sh_rx),
        .done (sh_done),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .miso (spi_miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= FR_POLL;
            idx      <= '0;
            inflight <= 1'b0;
            cur_addr <= '0;
            left     <= '0;
            big_q    <= 1'b0;
            poll_cnt <= '0;
            gap_cnt  <= '0;
            wip_q    <= 1'b0;
            sh_start <= 1'b0;
            cs_n_q   <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            sh_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        cur_addr <= start_addr;
                        left     <= byte_len;
                        big_q    <= big_unit;
                        busy     <= 1'b1;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!rng_ok) begin
                        err   <= 1'b1;
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else if (rng_empty) begin
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        kind     <= FR_POLL;
                        poll_cnt <= '0;
                        idx      <= '0;
                        inflight <= 1'b0;
                        cs_n_q   <= 1'b0;
                        state    <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (!inflight) begin
                        sh_start <= 1'b1;
                        inflight <= 1'b1;
                    end else if (sh_done) begin
                        inflight <= 1'b0;
                        if (idx == frame_last(kind)) begin
                            cs_n_q  <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                            if (kind == FR_POLL) begin
                                wip_q    <= sh_rx[0];
                                poll_cnt <= poll_cnt + 1'b1;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (gap_cnt != GW'(GAP_CYC - 1)) begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end else begin
                        idx <= '0;
                        case (kind)
                            FR_POLL: begin
                                if (wip_q && poll_cnt == PW'(POLL_LIMIT)) begin
                                    err   <= 1'b1;
                                    busy  <= 1'b0;
                                    state <= ST_IDLE;
                                end else begin
                                    if (!wip_q) kind <= FR_WREN;
                                    cs_n_q <= 1'b0;
                                    state  <= ST_FRAME;
                                end
                            end
                            FR_WREN: begin
                                kind   <= FR_ERASE;
                                cs_n_q <= 1'b0;
                                state  <= ST_FRAME;
                            end
                            default: begin
                                cur_addr <= cur_addr + unit_len[ADDR_W-1:0];
                                left     <= left - unit_len;
                                if (left == unit_len) begin
                                    done  <= 1'b1;
                                    busy  <= 1'b0;
                                    state <= ST_IDLE;
                                end else begin
                                    kind     <= FR_POLL;
                                    poll_cnt <= '0;
                                    cs_n_q   <= 1'b0;
                                    state    <= ST_FRAME;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // ---------------- checks ----------------
    frame_e        prev_kind;
    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_kind <= FR_POLL;
            hi_cnt    <= GW'(GAP_CYC);
        end else begin
            if (state == ST_GAP && gap_cnt == GW'(GAP_CYC - 1)) prev_kind <= kind;
            if (!spi_cs_n)                 hi_cnt <= '0;
            else if (hi_cnt != GW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R9
    pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done || err));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done || err) |=> !(done || err));

    // R3
    check_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |-> spi_cs_n);

    // R5
    wren_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && kind == FR_WREN) |-> !wip_q);

    // R6
    wren_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && kind == FR_ERASE) |-> prev_kind == FR_WREN);

    // R8
    poll_cap_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= PW'(POLL_LIMIT));

    // R10
    go_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && go) |=> $stable(big_q));

    // R11
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> hi_cnt >= GW'(GAP_CYC));

endmodule

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb;

    localparam int HALF  = 1;
    localparam int LIMIT = 8;

    typedef struct packed {
        logic [23:0] s;
        logic [24:0] l;
        logic        big;
        logic        bad;
        logic [3:0]  ner;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{24'h000000, 25'h0001000, 1'b0, 1'b0, 4'd1},
        '{24'h003000, 25'h0003000, 1'b0, 1'b0, 4'd3},
        '{24'h004000, 25'h0008000, 1'b1, 1'b0, 4'd2},
        '{24'h00F000, 25'h0001000, 1'b0, 1'b0, 4'd1},
        '{24'h00F000, 25'h0002000, 1'b0, 1'b1, 4'd0},
        '{24'h001800, 25'h0001000, 1'b0, 1'b1, 4'd0},
        '{24'h001000, 25'h0000800, 1'b0, 1'b1, 4'd0},
        '{24'h001000, 25'h0004000, 1'b1, 1'b1, 4'd0},
        '{24'h000000, 25'h0000000, 1'b0, 1'b0, 4'd0},
        '{24'h00C000, 25'h0004000, 1'b1, 1'b0, 4'd1},
        '{24'h000000, 25'h0010000, 1'b1, 1'b0, 4'd4},
        '{24'h020000, 25'h0000000, 1'b0, 1'b1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        big = 1'b0;
    logic        miso = 1'b0;
    logic [23:0] s_in = '0;
    logic [24:0] l_in = '0;
    logic        busy, done, err, sclk, cs_n, mosi;

    always #4 clk = ~clk;

    nor_erase_seq #(
        .DEV_LOG2  (16),
        .SECT_LOG2 (14),
        .SMALL_LOG2(12),
        .POLL_LIMIT(LIMIT),
        .SCLK_HALF (HALF)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .start_addr(s_in),
        .byte_len  (l_in),
        .big_unit  (big),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso)
    );

    // ---------------- flash model ----------------
    int          preset_wip = 0;
    int          busy_polls = 2;
    logic        arm_tog = 1'b0;
    int          wip_left = 0, n_er = 0, polls = 0, frames = 0;
    int          proto_bad = 0, sclk_bad = 0, bitn = 0;
    logic        wel = 1'b0, arm_q = 1'b0, cs_q = 1'b1, sclk_q = 1'b0;
    logic [7:0]  shreg = '0, stat;
    logic [7:0]  fb [4];
    logic [7:0]  er_op [16];
    logic [23:0] er_addr [16];

    always begin
        @(sclk or cs_n or arm_tog);
        if (arm_tog != arm_q) begin
            arm_q = arm_tog; wip_left = preset_wip; wel = 1'b0;
            n_er = 0; polls = 0; frames = 0; proto_bad = 0;
        end
        if (cs_n !== cs_q) begin
            if (cs_n === 1'b0) begin
                bitn = 0; frames++;
            end else if (cs_n === 1'b1 && cs_q === 1'b0) begin
                if (bitn % 8 != 0 || bitn == 0) proto_bad++;
                else begin
                    case (fb[0])
                        8'h05: begin
                            if (bitn != 16) proto_bad++;
                            polls++;
                            if (wip_left > 0) wip_left--;
                        end
                        8'h06: if (bitn != 8) proto_bad++; else wel = 1'b1;
                        8'h20, 8'hD8: begin
                            if (bitn != 32 || !wel || n_er >= 16) proto_bad++;
                            else begin
                                er_op[n_er] = fb[0];
                                er_addr[n_er] = {fb[1], fb[2], fb[3]};
                                n_er++; wel = 1'b0; wip_left = busy_polls;
                            end
                        end
                        default: proto_bad++;
                    endcase
                end
            end
            cs_q = cs_n;
        end
        if (sclk !== sclk_q) begin
            if ((sclk_q === 1'b0 || sclk_q === 1'b1) && cs_n !== 1'b0) sclk_bad++;
            if (sclk === 1'b1 && sclk_q === 1'b0) begin
                shreg = {shreg[6:0], mosi};
                bitn++;
                if (bitn % 8 == 0 && bitn <= 32) fb[bitn/8 - 1] = shreg;
            end else if (sclk === 1'b0 && sclk_q === 1'b1) begin
                stat = {6'b0, wel, (wip_left > 0)};
                if (bitn >= 8 && bitn < 16 && fb[0] == 8'h05) miso = stat[15 - bitn];
                else miso = 1'b0;
            end
            sclk_q = sclk;
        end
    end

    // chip-select gap monitor (R11)
    int gap_bad = 0, hi = 1000;
    always @(negedge clk) begin
        if (cs_n === 1'b1) hi++;
        else if (cs_n === 1'b0) begin
            if (hi > 0 && hi < 4 * HALF) gap_bad++;
            hi = 0;
        end
    end

    // ---------------- checking ----------------
    int tests = 0, fails = 0;

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic arm(input int wip0, input int bp);
        preset_wip = wip0;
        busy_polls = bp;
        arm_tog = ~arm_tog;
        #1;
    endtask

    task automatic run_req(input logic [23:0] s, input logic [24:0] l, input logic b,
                           input int poke, output int outcome);
        bit gap_seen;
        @(negedge clk);
        s_in = s; l_in = l; big = b; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy === 1'b1, "R9", "busy after go", busy, 1);
        outcome = 2;
        gap_seen = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (done === 1'b1 || err === 1'b1) begin
                outcome = (err === 1'b1) ? 1 : 0;
                break;
            end
            if (busy !== 1'b1) gap_seen = 1;
            if (poke > 0 && cyc == poke) begin
                s_in = 24'h0; l_in = 25'h1000; big = ~b; go = 1'b1;
            end else go = 1'b0;
            @(negedge clk);
        end
        go = 1'b0;
        chk(outcome != 2, "R9", "request completes", outcome, 0);
        chk(!gap_seen, "R9", "busy held until pulse", gap_seen, 0);
        chk(busy === 1'b0, "R9", "busy low in pulse cycle", busy, 0);
        chk(!(done === 1'b1 && err === 1'b1), "R9", "done and err exclusive", {done, err}, 0);
        @(negedge clk);
        chk(done === 1'b0 && err === 1'b0, "R9", "pulse lasts one cycle", {done, err}, 0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL R9 watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        int oc, fr;
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(busy === 0 && done === 0 && err === 0, "R1", "status in reset", {busy, done, err}, 0);
        chk(cs_n === 1 && sclk === 0, "R1", "bus idle in reset", {cs_n, sclk}, 2);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 0 && cs_n === 1 && sclk === 0, "R1", "idle after reset", {busy, cs_n, sclk}, 2);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 12; i++) begin
            int unit, ep;
            string tag;
            arm(0, 2);
            run_req(VEC[i].s, VEC[i].l, VEC[i].big, 0, oc);
            tag = VEC[i].bad ? "R2 R3" : (VEC[i].ner == 0 ? "R4" : "R7");
            chk(oc == int'(VEC[i].bad), tag, $sformatf("row %0d outcome", i), oc, VEC[i].bad);
            chk(n_er == int'(VEC[i].ner), "R7", $sformatf("row %0d erase count", i), n_er, VEC[i].ner);
            unit = VEC[i].big ? 32'h4000 : 32'h1000;
            for (int k = 0; k < n_er && k < int'(VEC[i].ner); k++) begin
                chk(er_addr[k] == VEC[i].s + 24'(k * unit), "R7",
                    $sformatf("row %0d unit %0d address", i, k), er_addr[k], VEC[i].s + 24'(k * unit));
                chk(er_op[k] == (VEC[i].big ? 8'hD8 : 8'h20), "R7",
                    $sformatf("row %0d unit %0d opcode", i, k), er_op[k], VEC[i].big ? 8'hD8 : 8'h20);
            end
            ep = (VEC[i].ner == 0) ? 0 : 1 + 3 * (int'(VEC[i].ner) - 1);
            chk(polls == ep, "R5", $sformatf("row %0d poll count", i), polls, ep);
            chk(proto_bad == 0, "R6", $sformatf("row %0d framing", i), proto_bad, 0);
            if (VEC[i].ner == 0)
                chk(frames == 0, VEC[i].bad ? "R3" : "R4", $sformatf("row %0d no bus", i), frames, 0);
        end

        // R8: flash never idle before first unit
        arm(1000, 2);
        run_req(24'h002000, 25'h2000, 1'b0, 0, oc);
        chk(oc == 1, "R8", "first-unit timeout errors", oc, 1);
        chk(polls == LIMIT, "R8", "polls before giving up", polls, LIMIT);
        chk(n_er == 0, "R8", "no erase after timeout", n_er, 0);

        // R8: timeout in the middle of a range
        arm(0, 1000);
        run_req(24'h000000, 25'h3000, 1'b0, 0, oc);
        chk(oc == 1, "R8", "mid-range timeout errors", oc, 1);
        chk(n_er == 1, "R8", "erases before timeout", n_er, 1);
        chk(polls == 1 + LIMIT, "R8", "total polls", polls, 1 + LIMIT);
        fr = frames;
        repeat (100) @(negedge clk);
        chk(frames == fr && cs_n === 1, "R8", "no frames after error", frames, fr);

        // R10: go while busy is ignored
        arm(0, 2);
        run_req(24'h008000, 25'h2000, 1'b0, 10, oc);
        chk(oc == 0, "R10", "original request completes", oc, 0);
        chk(n_er == 2, "R10", "erase count unchanged", n_er, 2);
        chk(er_addr[0] == 24'h008000 && er_addr[1] == 24'h009000, "R10", "addresses unchanged",
            er_addr[0], 24'h008000);
        chk(er_op[0] == 8'h20 && er_op[1] == 8'h20, "R10", "unit unchanged", er_op[1], 8'h20);
        fr = frames;
        repeat (20) @(negedge clk);
        chk(busy === 0 && frames == fr, "R10", "nothing queued", busy, 0);

        // R11 bus discipline over the whole run
        chk(sclk_bad == 0, "R11", "sclk edges outside select", sclk_bad, 0);
        chk(gap_bad == 0, "R11", "short deselect gaps", gap_bad, 0);

        summary();
        $finish;
    end

endmodule